// File: doc/BRIEF.md
# PLL Holdover Controller

This block decides, clock by clock, whether the charge pump of a phase-locked loop is driving or is held in high impedance (holdover). Holdover keeps the VCO near its last frequency when the reference goes away, instead of letting the charge pump rail the tuning voltage. The phase detector, the dividers and the analog loop sit outside the block. They appear here only as a reference-path PFD strobe, a digital lock-detect flag and a lock-detect pin level.

The block has two ways to enter holdover. In manual mode, a falling edge on an asynchronous sync pin enters holdover. Once the pin is high again, the next reference strobe releases the charge pump and resets the feedback B-counter in that same cycle. In automatic mode, a drop of digital lock detect enters holdover while the PLL is enabled and the lock-detect pin reads high; a configuration bit can tell the block to treat that pin as always high. The next reference strobe releases the charge pump. Automatic entry is then blocked until lock detect has stayed high across a programmable number of reference strobes.

Holdover works only when both enable bits are set. While holdover is enabled, the block blocks VCO calibration requests and flags them.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: In the cycle after a synchronous active-high reset, `cp_hiz_o`, `bcnt_rst_o`, `cal_go_o` and `cal_blocked_o` are all 0.
- R2: Unless both `hold_en_a_i` and `hold_en_b_i` are 1, `cp_hiz_o` is 0 from the next clock edge on, and no sync or lock-detect activity changes that.
- R3: With manual mode on, a high-to-low change of `sync_pin_i` sets `cp_hiz_o` at the third rising clock edge after the change: two edges in the synchroniser and one in the state register.
- R4: Manual entry responds only to edges. If `sync_pin_i` is already low when manual mode is switched on, `cp_hiz_o` stays 0.
- R5: A manual holdover ends only on a reference strobe that comes after `sync_pin_i` has returned high and has passed the synchroniser. Strobes that arrive while the pin is low, or before the return has been seen, leave `cp_hiz_o` at 1.
- R6: `cp_hiz_o` drops at the end of a manual holdover, and at that same clock edge `bcnt_rst_o` is 1 for exactly one cycle. An automatic release never pulses `bcnt_rst_o`.
- R7: If a synchronised sync falling edge and a reference strobe coincide while a manual release is pending, entry wins and `cp_hiz_o` stays 1.
- R8: With automatic mode on and `pll_en_i` high, a 1-to-0 change of `dld_i` sets `cp_hiz_o` at the next clock edge when the effective lock-detect level is high.
- R9: When `use_ld_pin_i` is 1, the effective lock-detect level is `ld_pin_i`. When it is 0, the level counts as 1.
- R10: An automatic holdover ends at the clock edge that samples the next `ref_pfd_i` strobe.
- R11: After an automatic release, a drop of `dld_i` does not re-enter holdover until `dld_i` has been high for N strobes in a row. N is `relock_thr_i`, or 5 if that value is below 5. A low `dld_i` restarts the count.
- R12: A `cal_req_i` pulse gives a one-cycle pulse one edge later: on `cal_blocked_o` when holdover is enabled, otherwise on `cal_go_o`. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_pin_i | input | 1 | Asynchronous manual-holdover pin, idle high |
| ref_pfd_i | input | 1 | One-cycle strobe per reference-path PFD event |
| dld_i | input | 1 | Digital lock detect, synchronous |
| ld_pin_i | input | 1 | Lock-detect pin level |
| pll_en_i | input | 1 | PLL enabled |
| hold_en_a_i | input | 1 | Holdover enable, first bit |
| hold_en_b_i | input | 1 | Holdover enable, second bit |
| manual_en_i | input | 1 | Manual mode on |
| auto_en_i | input | 1 | Automatic mode on |
| use_ld_pin_i | input | 1 | 1: use lock-detect pin level; 0: treat it as high |
| relock_thr_i | input | RELOCK_W | Relock strobe count (minimum 5) |
| cal_req_i | input | 1 | VCO calibration request pulse |
| cp_hiz_o | output | 1 | Charge pump high impedance |
| bcnt_rst_o | output | 1 | One-cycle feedback B-counter reset |
| cal_go_o | output | 1 | Calibration request passed on |
| cal_blocked_o | output | 1 | Calibration request refused |

## Verification
Every output comes from a register, so each result is due a fixed number of edges after its cause: three edges after a sync pin change, one edge after a lock-detect drop, a reference strobe or a calibration request. The bench drives inputs on the falling clock edge and samples on the next falling edge. A cycle model in the bench advances on the same rising edges as the design. Directed phases also count edges explicitly, check the exact edge where `cp_hiz_o` changes, and check that the B-counter pulse lasts only one cycle.

// File: rtl/hov_pkg.sv
package hov_pkg;

    typedef enum logic [2:0] {
        HOV_IDLE             = 3'd0,
        HOV_MAN_HOLD         = 3'd1,
        HOV_MAN_WAIT_REF     = 3'd2,
        HOV_AUTO_HOLD        = 3'd3,
        HOV_AUTO_WAIT_RELOCK = 3'd4
    } hov_state_e;

    typedef struct packed {
        logic manual_en;
        logic auto_en;
        logic use_ld_pin;
    } hov_cfg_t;

    localparam int HOV_RELOCK_MIN = 5;

    function automatic logic hov_is_hiz(hov_state_e s);
        return (s == HOV_MAN_HOLD) || (s == HOV_MAN_WAIT_REF) ||
               (s == HOV_AUTO_HOLD);
    endfunction

endpackage

// File: rtl/hov_sync_edge.sv
module hov_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/hov_relock_ctr.sv
module hov_relock_ctr #(
    parameter int W   = 8,
    parameter int MIN = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         dld_i,
    input  logic         pfd_i,
    input  logic [W-1:0] thr_i,
    output logic         done_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN);

    logic [W-1:0] cnt_q;
    logic [W-1:0] thr_eff;

    assign thr_eff = (thr_i < MIN_V) ? MIN_V : thr_i;
    assign done_o  = run_i & dld_i & pfd_i & (cnt_q == thr_eff - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || !dld_i) cnt_q <= '0;
        else if (pfd_i)              cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/hov_fsm.sv
module hov_fsm
    import hov_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hov_cfg_t   cfg_i,
    input  logic       hold_en_i,
    input  logic       sync_lvl_i,
    input  logic       sync_fall_i,
    input  logic       dld_i,
    input  logic       ld_pin_i,
    input  logic       pll_en_i,
    input  logic       pfd_i,
    input  logic       relock_done_i,
    output hov_state_e state_o,
    output logic       hiz_o,
    output logic       brst_o
);
    hov_state_e st_q, st_d;
    logic       dld_q;
    logic       dld_fall, ld_ok, auto_trig, man_trig, brst_d;
    logic       hiz_q, brst_q;

    assign dld_fall  = dld_q & ~dld_i;
    assign ld_ok     = cfg_i.use_ld_pin ? ld_pin_i : 1'b1;
    assign man_trig  = cfg_i.manual_en & sync_fall_i;
    assign auto_trig = cfg_i.auto_en & pll_en_i & dld_fall & ld_ok;

    always_comb begin
        st_d   = st_q;
        brst_d = 1'b0;
        if (!hold_en_i) begin
            st_d = HOV_IDLE;
        end else begin
            unique case (st_q)
                HOV_IDLE: begin
                    if (man_trig)       st_d = HOV_MAN_HOLD;
                    else if (auto_trig) st_d = HOV_AUTO_HOLD;
                end
                HOV_MAN_HOLD: begin
                    if (sync_lvl_i) st_d = HOV_MAN_WAIT_REF;
                end
                HOV_MAN_WAIT_REF: begin
                    if (sync_fall_i) begin
                        st_d = HOV_MAN_HOLD;
                    end else if (pfd_i) begin
                        st_d   = HOV_IDLE;
                        brst_d = 1'b1;
                    end
                end
                HOV_AUTO_HOLD: begin
                    if (pfd_i) st_d = HOV_AUTO_WAIT_RELOCK;
                end
                HOV_AUTO_WAIT_RELOCK: begin
                    if (man_trig)           st_d = HOV_MAN_HOLD;
                    else if (relock_done_i) st_d = HOV_IDLE;
                end
                default: st_d = HOV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HOV_IDLE;
            dld_q  <= 1'b0;
            hiz_q  <= 1'b0;
            brst_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            dld_q  <= dld_i;
            hiz_q  <= hov_is_hiz(st_d);
            brst_q <= brst_d;
        end
    end

    assign state_o = st_q;
    assign hiz_o   = hiz_q;
    assign brst_o  = brst_q;
endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl
    import hov_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RELOCK_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_pin_i,
    input  logic                ref_pfd_i,
    input  logic                dld_i,
    input  logic                ld_pin_i,
    input  logic                pll_en_i,
    input  logic                hold_en_a_i,
    input  logic                hold_en_b_i,
    input  logic                manual_en_i,
    input  logic                auto_en_i,
    input  logic                use_ld_pin_i,
    input  logic [RELOCK_W-1:0] relock_thr_i,
    input  logic                cal_req_i,
    output logic                cp_hiz_o,
    output logic                bcnt_rst_o,
    output logic                cal_go_o,
    output logic                cal_blocked_o
);
    hov_cfg_t   cfg;
    hov_state_e state;
    logic       hold_en, sync_lvl, sync_fall, relock_done;
    logic       cal_go_q, cal_blk_q;

    assign hold_en        = hold_en_a_i & hold_en_b_i;
    assign cfg.manual_en  = manual_en_i;
    assign cfg.auto_en    = auto_en_i;
    assign cfg.use_ld_pin = use_ld_pin_i;

    hov_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (sync_pin_i),
        .lvl_o  (sync_lvl),
        .fall_o (sync_fall)
    );

    hov_relock_ctr #(.W(RELOCK_W), .MIN(HOV_RELOCK_MIN)) u_relock (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state == HOV_AUTO_WAIT_RELOCK),
        .dld_i  (dld_i),
        .pfd_i  (ref_pfd_i),
        .thr_i  (relock_thr_i),
        .done_o (relock_done)
    );

    hov_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cfg_i         (cfg),
        .hold_en_i     (hold_en),
        .sync_lvl_i    (sync_lvl),
        .sync_fall_i   (sync_fall),
        .dld_i         (dld_i),
        .ld_pin_i      (ld_pin_i),
        .pll_en_i      (pll_en_i),
        .pfd_i         (ref_pfd_i),
        .relock_done_i (relock_done),
        .state_o       (state),
        .hiz_o         (cp_hiz_o),
        .brst_o        (bcnt_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_go_q  <= 1'b0;
            cal_blk_q <= 1'b0;
        end else begin
            cal_go_q  <= cal_req_i & ~hold_en;
            cal_blk_q <= cal_req_i &  hold_en;
        end
    end

    assign cal_go_o      = cal_go_q;
    assign cal_blocked_o = cal_blk_q;
endmodule

// File: rtl/pll_holdover_ctrl_chk.sv
module pll_holdover_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ref_pfd_i,
    input logic hold_en_a_i,
    input logic hold_en_b_i,
    input logic cal_req_i,
    input logic cp_hiz_o,
    input logic bcnt_rst_o,
    input logic cal_go_o,
    input logic cal_blocked_o
);
    logic hold_en;
    assign hold_en = hold_en_a_i & hold_en_b_i;

    // R2
    a_r2_disabled_no_hiz: assert property (@(posedge clk) disable iff (rst)
        !hold_en |=> !cp_hiz_o);

    // R5, R10
    a_r5_release_on_ref: assert property (@(posedge clk) disable iff (rst)
        $fell(cp_hiz_o) |-> ($past(ref_pfd_i) || !$past(hold_en)));

    // R6
    a_r6_bcnt_single: assert property (@(posedge clk) disable iff (rst)
        bcnt_rst_o |=> !bcnt_rst_o);

    // R6
    a_r6_bcnt_at_release: assert property (@(posedge clk) disable iff (rst)
        bcnt_rst_o |-> (!cp_hiz_o && $past(cp_hiz_o)));

    // R12
    a_r12_cal_refused: assert property (@(posedge clk) disable iff (rst)
        (cal_req_i && hold_en) |=> (cal_blocked_o && !cal_go_o));

    // R12
    a_r12_cal_passed: assert property (@(posedge clk) disable iff (rst)
        (cal_req_i && !hold_en) |=> (cal_go_o && !cal_blocked_o));
endmodule

bind pll_holdover_ctrl pll_holdover_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ref_pfd_i     (ref_pfd_i),
    .hold_en_a_i   (hold_en_a_i),
    .hold_en_b_i   (hold_en_b_i),
    .cal_req_i     (cal_req_i),
    .cp_hiz_o      (cp_hiz_o),
    .bcnt_rst_o    (bcnt_rst_o),
    .cal_go_o      (cal_go_o),
    .cal_blocked_o (cal_blocked_o)
);

// File: tb/pll_holdover_ctrl_tb_top.sv
module pll_holdover_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RW         = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_pin = 1'b1, ref_pfd = 1'b0, dld = 1'b0, ld_pin = 1'b0;
    logic pll_en = 1'b0, en_a = 1'b0, en_b = 1'b0;
    logic man_en = 1'b0, auto_en = 1'b0, use_ld = 1'b0, cal_req = 1'b0;
    logic [RW-1:0] thr = 8'd5;
    logic cp_hiz, bcnt_rst, cal_go, cal_blk;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_holdover_ctrl dut_i (
        .clk(clk), .rst(rst), .sync_pin_i(sync_pin), .ref_pfd_i(ref_pfd),
        .dld_i(dld), .ld_pin_i(ld_pin), .pll_en_i(pll_en),
        .hold_en_a_i(en_a), .hold_en_b_i(en_b), .manual_en_i(man_en),
        .auto_en_i(auto_en), .use_ld_pin_i(use_ld), .relock_thr_i(thr),
        .cal_req_i(cal_req), .cp_hiz_o(cp_hiz), .bcnt_rst_o(bcnt_rst),
        .cal_go_o(cal_go), .cal_blocked_o(cal_blk)
    );

    // ---------------- cycle model built from the requirements ----------
    localparam int M_IDLE = 0, M_MH = 1, M_MW = 2, M_AH = 3, M_AW = 4;
    logic m_s1, m_s2, m_s3, m_dq, m_hiz, m_b, m_go, m_blk;
    int   m_st, m_cnt;

    function automatic int eff_thr(logic [RW-1:0] t);
        return (int'(t) < 5) ? 5 : int'(t);
    endfunction

    function automatic logic hiz_of(int s);
        return (s == M_MH) || (s == M_MW) || (s == M_AH);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1; m_dq <= 1'b0;
            m_st <= M_IDLE; m_cnt <= 0;
            m_hiz <= 1'b0; m_b <= 1'b0; m_go <= 1'b0; m_blk <= 1'b0;
        end else begin
            automatic logic en    = en_a & en_b;
            automatic logic fall  = m_s3 & ~m_s2;
            automatic logic ldok  = use_ld ? ld_pin : 1'b1;
            automatic logic dfall = m_dq & ~dld;
            automatic int   ns    = m_st;
            automatic logic b     = 1'b0;
            if (!en) ns = M_IDLE;
            else case (m_st)
                M_IDLE: if (man_en && fall) ns = M_MH;
                        else if (auto_en && pll_en && dfall && ldok) ns = M_AH;
                M_MH:   if (m_s2) ns = M_MW;
                M_MW:   if (fall) ns = M_MH;
                        else if (ref_pfd) begin ns = M_IDLE; b = 1'b1; end
                M_AH:   if (ref_pfd) ns = M_AW;
                M_AW:   if (man_en && fall) ns = M_MH;
                        else if (ref_pfd && dld && m_cnt == eff_thr(thr) - 1) ns = M_IDLE;
                default: ns = M_IDLE;
            endcase
            if (m_st != M_AW || !dld) m_cnt <= 0;
            else if (ref_pfd)         m_cnt <= m_cnt + 1;
            m_s1 <= sync_pin; m_s2 <= m_s1; m_s3 <= m_s2; m_dq <= dld;
            m_st <= ns; m_hiz <= hiz_of(ns); m_b <= b;
            m_go <= cal_req & ~en; m_blk <= cal_req & en;
        end
    end

    // ---------------- checking helpers ---------------------------------
    task automatic check(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        check({cur_req, " cp_hiz model"}, cp_hiz, m_hiz);
        check("R6 bcnt_rst model", bcnt_rst, m_b);
        check("R12 cal_go model", cal_go, m_go);
        check("R12 cal_blocked model", cal_blk, m_blk);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cmp_model();
        end
    endtask

    task automatic pfd_pulse();
        ref_pfd = 1'b1; step(); ref_pfd = 1'b0;
    endtask

    task automatic relock(int k);
        dld = 1'b1;
        for (int i = 0; i < k; i++) begin pfd_pulse(); step(); end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cp_hiz", cp_hiz, 1'b0);
        check("R1 bcnt_rst", bcnt_rst, 1'b0);
        check("R1 cal_go", cal_go, 1'b0);
        check("R1 cal_blocked", cal_blk, 1'b0);

        // R2: only one enable bit set
        cur_req = "R2";
        en_a = 1'b1; man_en = 1'b1; sync_pin = 1'b0;
        step(5);
        check("R2 one enable bit", cp_hiz, 1'b0);
        cal_req = 1'b1; step(); cal_req = 1'b0;
        check("R12 cal passed when disabled", cal_go, 1'b1);
        sync_pin = 1'b1; step(4);

        // R3: manual entry latency
        cur_req = "R3";
        en_b = 1'b1; step(2);
        sync_pin = 1'b0;
        step(); check("R3 edge 1", cp_hiz, 1'b0);
        step(); check("R3 edge 2", cp_hiz, 1'b0);
        step(); check("R3 edge 3", cp_hiz, 1'b1);
        // R5: strobes while low or before sync seen high
        cur_req = "R5";
        step(6); pfd_pulse(); step();
        check("R5 strobe while pin low", cp_hiz, 1'b1);
        sync_pin = 1'b1; step();
        pfd_pulse();
        check("R5 strobe before sync seen", cp_hiz, 1'b1);
        step(3);
        check("R5 waits for strobe", cp_hiz, 1'b1);
        pfd_pulse();
        check("R5 released", cp_hiz, 1'b0);
        check("R6 bcnt pulse", bcnt_rst, 1'b1);
        step();
        check("R6 bcnt one cycle", bcnt_rst, 1'b0);

        // R7: fall and strobe together
        cur_req = "R7";
        sync_pin = 1'b0; step(3); sync_pin = 1'b1; step(4);
        sync_pin = 1'b0; step(2);
        pfd_pulse();
        check("R7 entry wins", cp_hiz, 1'b1);
        check("R7 no bcnt", bcnt_rst, 1'b0);
        sync_pin = 1'b1; step(4); pfd_pulse(); step();

        // R4: pin already low when manual mode switched on
        cur_req = "R4";
        man_en = 1'b0; sync_pin = 1'b0; step(5);
        man_en = 1'b1; step(5);
        check("R4 level ignored", cp_hiz, 1'b0);
        man_en = 1'b0; sync_pin = 1'b1; step(4);

        // R8 / R10: automatic entry and release
        cur_req = "R8";
        auto_en = 1'b1; pll_en = 1'b1; use_ld = 1'b1; ld_pin = 1'b1; dld = 1'b1;
        thr = 8'd3; step(3);
        dld = 1'b0; step();
        check("R8 auto entry", cp_hiz, 1'b1);
        cur_req = "R10";
        step(3); pfd_pulse();
        check("R10 auto release", cp_hiz, 1'b0);
        check("R6 no bcnt on auto release", bcnt_rst, 1'b0);

        // R11: relock count (threshold 3 clamps to 5)
        cur_req = "R11";
        relock(4);
        dld = 1'b0; step();
        check("R11 blocked after 4", cp_hiz, 1'b0);
        relock(5);
        dld = 1'b0; step();
        check("R11 rearmed after 5", cp_hiz, 1'b1);
        pfd_pulse(); relock(5);

        // R9: lock-detect pin use
        cur_req = "R9";
        ld_pin = 1'b0; dld = 1'b0; step();
        check("R9 pin low blocks", cp_hiz, 1'b0);
        dld = 1'b1; use_ld = 1'b0; step();
        dld = 1'b0; step();
        check("R9 pin ignored", cp_hiz, 1'b1);
        pfd_pulse(); relock(5);

        // R12: calibration while enabled
        cal_req = 1'b1; step(); cal_req = 1'b0;
        check("R12 cal blocked", cal_blk, 1'b1);
        check("R12 cal not passed", cal_go, 1'b0);

        // random mix against the model
        cur_req = "R3/R8/R11";
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 6000; c++) begin
            ref_pfd = ($urandom % 4) == 0;
            cal_req = ($urandom % 20) == 0;
            if ($urandom % 40 == 0)  sync_pin = ~sync_pin;
            if ($urandom % 25 == 0)  dld = ~dld;
            if ($urandom % 50 == 0)  ld_pin = ~ld_pin;
            if ($urandom % 300 == 0) man_en = ~man_en;
            if ($urandom % 300 == 0) auto_en = ~auto_en;
            if ($urandom % 300 == 0) use_ld = ~use_ld;
            if ($urandom % 400 == 0) en_b = ~en_b;
            if ($urandom % 500 == 0) pll_en = ~pll_en;
            if ($urandom % 200 == 0) thr = RW'($urandom % 12);
            step();
        end
        ref_pfd = 1'b0; cal_req = 1'b0;
        step(4);
        finish_run();
    end
endmodule